// File: doc/BRIEF.md
# Quad-Pumped Data Bus Transmitter with Per-Group Inversion

This block puts a 256-bit line onto a 64-bit active-low data bus as four 64-bit sub-phases. The words go out lowest first. A rate enable steps the sub-phases at the bus transfer rate, four per common clock period. For each sub-phase, the 64-bit word is cut into four 16-bit groups, and each group is judged on its own. If more than half of a group's bits would be pulled electrically low, the group is sent complemented. A per-group active-low flag travels with the data and marks the complemented groups.

A line arrives through a valid/ready handshake. The block takes a line only when the downstream bus is granted and the block is not already sending. From the cycle after acceptance it holds an active-low busy line and an active-low ready-data line asserted. Both stay asserted until the fourth sub-phase is stepped out. The bus wires then float back to their released (all high) level. If the grant is withdrawn during a transfer, the current sub-phase stays frozen on the wires.

Top module: `qp_bus_tx`

## Requirements
- R1: After reset, `dbsy_n`, `drdy_n`, every `bus_d_n` bit and every `bus_inv_n` bit are high, and `in_ready` follows `bus_grant`.
- R2: `in_ready` is high exactly when `bus_grant` is high and no transfer is in progress. A line is captured on a clock edge where `in_valid` and `in_ready` are both high. Offers made while a transfer is in progress are ignored.
- R3: Sub-phase k (k = 0..3) presents bits [64k+63:64k] of the captured line. Sub-phase 0 is shown in the cycle after capture. The block moves to the next sub-phase on each edge where `xfer_en` and `bus_grant` are both high.
- R4: Group g occupies bits [16g+15:16g] of the sub-phase word. It is complemented when more than 8 of its 16 logical bits are 1, since a logical 1 is driven electrically low. With exactly 8 ones it is not complemented.
- R5: `bus_inv_n[g]` is low in exactly the sub-phases where group g is complemented.
- R6: The bus is active-low. A group that is not complemented drives `~bits` on `bus_d_n`, and a complemented group drives `bits` unchanged. So no group ever has more than 8 wires low.
- R7: `drdy_n` is low in every cycle in which a sub-phase is presented, and high otherwise.
- R8: `dbsy_n` is low from the cycle after capture through the fourth sub-phase. It goes high on the edge that steps past sub-phase 3. While it is high, `bus_d_n` and `bus_inv_n` are all ones.
- R9: While `bus_grant` is low during a transfer, `xfer_en` has no effect, and the presented sub-phase and its flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A line is offered |
| in_data | input | 256 | Offered line, sub-phase 0 in the low 64 bits |
| in_ready | output | 1 | Line will be taken on this edge |
| bus_grant | input | 1 | Downstream data bus is granted to this agent |
| xfer_en | input | 1 | Transfer-rate enable that steps the sub-phase |
| bus_d_n | output | 64 | Active-low data wires |
| bus_inv_n | output | 4 | Active-low per-group inversion flags |
| drdy_n | output | 1 | Active-low data-ready marker |
| dbsy_n | output | 1 | Active-low data-bus-busy |

## Verification
Two things can fall in the same cycle. One is stepping past the final sub-phase, which releases the bus. The other is a new line offered on `in_valid`, which must be refused until the block is idle. The bench holds a different, complemented line on `in_valid` through whole transfers, including the edge that steps out sub-phase 3. It then checks that every sub-phase still shows the original line and that the bus is released for one idle cycle. Withdrawing the grant in the same cycle as a `xfer_en` pulse is checked by confirming that the wires and flags do not move.

// File: rtl/qp_bus_tx.sv
module qp_bus_tx #(
  parameter int GW     = 16,
  parameter int GROUPS = 4,
  parameter int PHASES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [GW*GROUPS*PHASES-1:0] in_data,
  output logic                        in_ready,
  input  logic                        bus_grant,
  input  logic                        xfer_en,
  output logic [GW*GROUPS-1:0]        bus_d_n,
  output logic [GROUPS-1:0]           bus_inv_n,
  output logic                        drdy_n,
  output logic                        dbsy_n
);
  localparam int BW  = GW * GROUPS;
  localparam int LW  = BW * PHASES;
  localparam int PHW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam int CW  = $clog2(GW + 1);

  logic [LW-1:0]  line_q;
  logic [PHW-1:0] phase_q;
  logic           busy_q;
  logic [BW-1:0]  word;
  logic [GROUPS-1:0] inv;

  wire advance = busy_q && xfer_en && bus_grant;
  wire last    = (phase_q == PHW'(PHASES - 1));

  assign in_ready = bus_grant && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      phase_q <= '0;
      busy_q  <= 1'b0;
    end else if (in_valid && in_ready) begin
      line_q  <= in_data;
      phase_q <= '0;
      busy_q  <= 1'b1;
    end else if (advance) begin
      if (last) begin
        busy_q  <= 1'b0;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign word = line_q[int'(phase_q)*BW +: BW];

  function automatic logic [CW-1:0] ones(input logic [GW-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < GW; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  for (genvar g = 0; g < GROUPS; g++) begin : grp
    wire [GW-1:0] bits = word[g*GW +: GW];
    assign inv[g] = busy_q && (int'(ones(bits)) > GW/2);
    assign bus_d_n[g*GW +: GW] = !busy_q ? {GW{1'b1}} : (inv[g] ? bits : ~bits);
    assign bus_inv_n[g] = ~inv[g];

    assert_low_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~bus_d_n[g*GW +: GW]) <= GW/2);
  end

  assign drdy_n = ~busy_q;
  assign dbsy_n = ~busy_q;

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !dbsy_n);

  assert_no_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dbsy_n |-> !in_ready);

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbsy_n |-> (&bus_d_n && &bus_inv_n && drdy_n));

  assert_release_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last) |=> dbsy_n);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbsy_n && !bus_grant) |=> ($stable(bus_d_n) && $stable(bus_inv_n) && !dbsy_n));
endmodule

// File: tb/tb_qp_bus_tx.sv
module tb_qp_bus_tx;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] in_data = '0;
  logic         in_ready;
  logic         bus_grant = 1'b0;
  logic         xfer_en = 1'b0;
  logic [63:0]  bus_d_n;
  logic [3:0]   bus_inv_n;
  logic         drdy_n;
  logic         dbsy_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qp_bus_tx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bus_grant(bus_grant), .xfer_en(xfer_en),
    .bus_d_n(bus_d_n), .bus_inv_n(bus_inv_n), .drdy_n(drdy_n), .dbsy_n(dbsy_n)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] w, output logic [63:0] d, output logic [3:0] f);
    for (int g = 0; g < 4; g++) begin
      int c = 0;
      for (int i = 0; i < 16; i++) c += w[16*g+i];
      f[g] = (c > 8) ? 1'b0 : 1'b1;
      d[16*g +: 16] = (c > 8) ? w[16*g +: 16] : ~w[16*g +: 16];
    end
  endfunction

  function automatic logic [15:0] pat(input int cnt, input int rot);
    logic [31:0] b = (32'd1 << cnt) - 1;
    logic [15:0] v = b[15:0];
    return (v << rot) | (v >> (16 - rot));
  endfunction

  task automatic check_idle(input string tag);
    check(dbsy_n === 1'b1, {tag, " R8 dbsy_n"}, 64'(dbsy_n), 64'd1);
    check(drdy_n === 1'b1, {tag, " R7 drdy_n"}, 64'(drdy_n), 64'd1);
    check(bus_d_n === '1, {tag, " R8 bus_d_n"}, bus_d_n, '1);
    check(bus_inv_n === 4'hF, {tag, " R8 bus_inv_n"}, 64'(bus_inv_n), 64'hF);
  endtask

  // collide: keep a different line offered during the whole transfer
  task automatic send(input logic [255:0] line, input int stall_ph, input bit collide);
    logic [63:0] ed;
    logic [3:0]  ef;
    bus_grant = 1'b1;
    in_valid  = 1'b1;
    in_data   = line;
    check(in_ready === 1'b1, "R2 in_ready idle", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = collide;
    in_data  = ~line;
    for (int p = 0; p < 4; p++) begin
      model(line[64*p +: 64], ed, ef);
      check(bus_d_n === ed, "R3 R4 R6 data", bus_d_n, ed);
      check(bus_inv_n === ef, "R4 R5 flags", 64'(bus_inv_n), 64'(ef));
      check(drdy_n === 1'b0 && dbsy_n === 1'b0, "R7 R8 busy/ready",
            64'({drdy_n, dbsy_n}), 64'd0);
      check(in_ready === 1'b0, "R2 in_ready busy", 64'(in_ready), 64'd0);
      if (p == stall_ph) begin
        bus_grant = 1'b0;
        xfer_en   = 1'b1;
        @(negedge clk);
        check(bus_d_n === ed && bus_inv_n === ef && dbsy_n === 1'b0,
              "R9 stall hold", bus_d_n, ed);
        bus_grant = 1'b1;
      end
      xfer_en = 1'b1;
      @(negedge clk);
      xfer_en = 1'b0;
    end
    check_idle("post");
    in_valid = 1'b0;
  endtask

  initial begin
    logic [255:0] line;
    logic [31:0]  lfsr = 32'hACE1_2468;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    check(in_ready === 1'b0, "R1 in_ready no grant", 64'(in_ready), 64'd0);
    bus_grant = 1'b1;
    #1;
    check(in_ready === 1'b1, "R1 in_ready grant", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");

    // popcount sweep: every count 0..16 hits every group and sub-phase (R4 boundary at 8)
    for (int k = 0; k < 17; k++) begin
      for (int p = 0; p < 4; p++)
        for (int g = 0; g < 4; g++)
          line[64*p + 16*g +: 16] = pat((k + 5*g + 7*p) % 17, (3*k + g + p) % 16);
      send(line, (k % 5 == 4) ? k % 4 : -1, k[0]);
    end

    // exactly 8 ones in every group: nothing inverted (R4)
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 4; g++)
        line[64*p + 16*g +: 16] = pat(8, (g * 5 + p) % 16);
    send(line, -1, 1'b1);

    // pseudo-random lines
    for (int n = 0; n < 40; n++) begin
      for (int j = 0; j < 8; j++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        line[32*j +: 32] = lfsr;
      end
      send(line, (n % 3 == 0) ? n % 4 : -1, n[1]);
    end

    // no grant: offer ignored (R2)
    bus_grant = 1'b0;
    in_valid  = 1'b1;
    in_data   = '1;
    @(negedge clk);
    @(negedge clk);
    check_idle("R2 no grant");
    in_valid = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule